// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers 32 peripheral interrupt lines into one parent request. Each source has one bit in every register. A per-source mask bit gates whether that source can drive the parent line. Software never writes the whole mask at once. Instead, one register sets mask bits (disables sources) and another clears them (enables sources), and only the bits written as 1 change. Because of this, two agents can enable or disable their own sources without a read-modify-write race.

A parameter picks one of two variants.

- **Latched:** each input is brought into the clock domain through a synchronizer, and a rising edge sets a sticky pending bit. Software acknowledges a pending bit by writing a 1 to it in a write-one-to-clear register.
- **Level:** the status register shows the synchronized live input levels, and there is no acknowledge register.

The parent output is high whenever any unmasked source shows status.

The register port accepts one access per cycle whenever `bus_valid` is high. It never applies back-pressure, so there is no ready signal. Read data is registered: it appears on `bus_rdata` in the cycle after the request, qualified by `bus_rvalid`.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask bit is 1 (all sources disabled), every pending bit is 0, and `irq_out` is low.
- R2: A write to the mask-set register sets exactly the mask bits written as 1 and leaves the others unchanged. Its offset is 0x10 when latched and 0x08 in the level variant.
- R3: A write to the mask-clear register clears exactly the mask bits written as 1 and leaves the others unchanged. Its offset is 0x14 when latched and 0x0C in the level variant.
- R4: Reading the mask-status register returns the current mask, where 1 means disabled. Its offset is 0x0C when latched and 0x04 in the level variant.
- R5: In the latched variant, a rising edge on a source sets its pending bit. The bit stays set after the source falls and reads back at offset 0x00.
- R6: In the latched variant, writing to offset 0x08 clears the pending bits written as 1; bits written as 0 are untouched.
- R7: In the latched variant, if a new rising edge and a clear write for the same bit fall in the same cycle, the bit ends up set.
- R8: `irq_out` is high exactly when (status AND NOT mask) is non-zero.
- R9: Masking a source keeps its latched pending bit. The bit still reads back, and it drives `irq_out` again once the source is unmasked.
- R10: In the level variant, offset 0x00 reads the synchronized input levels, and nothing is held after an input falls.
- R11: In the level variant, only offsets 0x00, 0x04, 0x08 and 0x0C are mapped. Writes to any other offset, including 0x10 and 0x14, change nothing.
- R12: A read returns its data one cycle after the request, with `bus_rvalid` high for that cycle. Reads of unmapped offsets return zero, and writes to unmapped or read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| bus_valid | input | 1 | Register access request, one per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | 1 | Parent interrupt request |

## Verification
The latched variant is driven with these source patterns:

- A single pulse on an unmasked source, which shows that the bit is sticky and that it raises the parent output.
- A pulse on a masked source, which separates the status value from the gated output.
- An acknowledge that lands in the same cycle as a fresh edge on one bit and clears another bit, which shows the priority of the edge over the clear.

The level variant is driven with multi-bit level patterns, both masked and unmasked, and then released. This separates a live level view from any latching. It also checks that the latched variant's offsets 0x10 and 0x14 are dead in this variant. Mask writes use partial patterns, so an implementation that writes the whole mask shows up as a wrong read-back.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_STATUS,
    RK_ACK,
    RK_MSTAT,
    RK_MSET,
    RK_MCLR
  } reg_kind_e;

  // Offset decode; the two variants place the mask registers differently.
  function automatic reg_kind_e reg_decode(input logic latched, input logic [7:0] off);
    reg_kind_e k;
    k = RK_NONE;
    if (latched) begin
      case (off)
        8'h00:   k = RK_STATUS;
        8'h08:   k = RK_ACK;
        8'h0C:   k = RK_MSTAT;
        8'h10:   k = RK_MSET;
        8'h14:   k = RK_MCLR;
        default: k = RK_NONE;
      endcase
    end else begin
      case (off)
        8'h00:   k = RK_STATUS;
        8'h04:   k = RK_MSTAT;
        8'h08:   k = RK_MSET;
        8'h0C:   k = RK_MCLR;
        default: k = RK_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture #(
  parameter int W       = 32,
  parameter int LATCHED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] status_o
);
  if (LATCHED != 0) begin : g_latched
    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] rise;

    assign rise = lvl_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        pend_q <= '0;
      end else begin
        prev_q <= lvl_i;
        // A new edge outranks a clear of the same bit.
        pend_q <= (pend_q & ~ack_i) | rise;
      end
    end

    assign status_o = pend_q;
  end else begin : g_level
    logic unused_inputs;
    assign unused_inputs = ^{ack_i, clk, rst_n};
    assign status_o      = lvl_i;
  end
endmodule

// File: rtl/irqagg_regfile.sv
module irqagg_regfile
  import irqagg_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int ADDR_W  = 5,
  parameter int LATCHED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              bus_rvalid,
  input  logic [NSRC-1:0]   status_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   ack_o
);
  localparam logic IS_LATCHED = (LATCHED != 0);

  reg_kind_e       kind;
  logic            wr_en;
  logic            rd_en;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] rd_mux;

  assign kind  = reg_decode(IS_LATCHED, 8'(bus_addr));
  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;
  assign ack_o = (wr_en && kind == RK_ACK) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en && kind == RK_MSET) begin
      mask_q <= mask_q | bus_wdata;
    end else if (wr_en && kind == RK_MCLR) begin
      mask_q <= mask_q & ~bus_wdata;
    end
  end

  always_comb begin
    case (kind)
      RK_STATUS: rd_mux = status_i;
      RK_MSTAT:  rd_mux = mask_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC        = 32,
  parameter int ADDR_W      = 5,
  parameter int LATCHED     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_out
);
  logic [NSRC-1:0] lvl_sync;
  logic [NSRC-1:0] ack_v;
  logic [NSRC-1:0] status_v;
  logic [NSRC-1:0] mask_q;

  irqagg_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(lvl_sync)
  );

  irqagg_capture #(.W(NSRC), .LATCHED(LATCHED)) u_capture (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync), .ack_i(ack_v), .status_o(status_v)
  );

  irqagg_regfile #(.NSRC(NSRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .status_i(status_v), .mask_o(mask_q), .ack_o(ack_v)
  );

  assign irq_out = |(status_v & ~mask_q);
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int ADDR_W  = 5,
  parameter int LATCHED = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NSRC-1:0]   bus_wdata,
  input logic [NSRC-1:0]   bus_rdata,
  input logic              bus_rvalid,
  input logic              irq_out,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   status_v
);
  localparam logic IS_LATCHED = (LATCHED != 0);

  reg_kind_e       k;
  logic            wr;
  logic            rd;
  logic [NSRC-1:0] clr_bits;

  assign k        = reg_decode(IS_LATCHED, 8'(bus_addr));
  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign clr_bits = (wr && k == RK_ACK) ? bus_wdata : '0;

  // R2
  a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && k == RK_MSET) |-> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && k == RK_MCLR) |-> ((mask_q & $past(bus_wdata)) == '0));

  // R4 / R12
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr && (k == RK_MSET || k == RK_MCLR)) |-> $stable(mask_q));

  // R12
  a_r12_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid == $past(rd));

  // R12
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && k == RK_NONE) |-> (bus_rdata == '0));

  // R8
  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (status_v != '0));

  if (LATCHED != 0) begin : g_lat_chk
    // R5 / R9: a pending bit only drops when acknowledged
    a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_v & $past(status_v & ~clr_bits)) == $past(status_v & ~clr_bits)));
  end
endmodule

bind irq_aggregator irqagg_checker #(
  .NSRC(NSRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)
) u_irqagg_checker (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .irq_out(irq_out), .mask_q(mask_q), .status_v(status_v)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        va = 1'b0, vb = 1'b0;
  logic        b_write = 1'b0;
  logic [4:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        rv_a, rv_b, irq_a, irq_b;

  int   total = 0;
  int   bad = 0;
  exp_t q_a[$];
  exp_t q_b[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.LATCHED(1)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src_a), .bus_valid(va), .bus_write(b_write),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rd_a), .bus_rvalid(rv_a),
    .irq_out(irq_a)
  );

  irq_aggregator #(.LATCHED(0)) u_irq_aggregator_lvl (
    .clk(clk), .rst_n(rst_n), .src_i(src_b), .bus_valid(vb), .bus_write(b_write),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rd_b), .bus_rvalid(rv_b),
    .irq_out(irq_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the next one.
  task automatic rd(input bit sel, input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp;
    e.tag = tag;
    if (sel) q_b.push_back(e); else q_a.push_back(e);
    b_write = 1'b0;
    b_addr  = a;
    if (sel) vb = 1'b1; else va = 1'b1;
    @(negedge clk);
    va = 1'b0;
    vb = 1'b0;
  endtask

  task automatic wr(input bit sel, input logic [4:0] a, input logic [31:0] d);
    b_write = 1'b1;
    b_addr  = a;
    b_wdata = d;
    if (sel) vb = 1'b1; else va = 1'b1;
    @(negedge clk);
    va = 1'b0;
    vb = 1'b0;
    b_write = 1'b0;
  endtask

  task automatic pulse_a(input int bitno);
    src_a[bitno] = 1'b1;
    repeat (3) @(negedge clk);
    src_a[bitno] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Monitors: pop the expected read value when read data appears.
  always @(negedge clk) begin
    if (rst_n && rv_a) begin
      if (q_a.size() == 0) chk("R12 unexpected rvalid A", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = q_a.pop_front();
        chk(e.tag, rd_a, e.exp);
      end
    end
    if (rst_n && rv_b) begin
      if (q_b.size() == 0) chk("R12 unexpected rvalid B", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = q_b.pop_front();
        chk(e.tag, rd_b, e.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Latched variant
    chk("R1 irq low after reset", {31'b0, irq_a}, 32'h0);
    rd(0, 5'h0C, 32'hFFFF_FFFF, "R1 R4 mask after reset");
    rd(0, 5'h00, 32'h0, "R1 pending after reset");
    wr(0, 5'h14, 32'h0000_00FF);
    rd(0, 5'h0C, 32'hFFFF_FF00, "R3 partial mask clear");
    wr(0, 5'h10, 32'h0000_000F);
    rd(0, 5'h0C, 32'hFFFF_FF0F, "R2 partial mask set");

    pulse_a(5);
    rd(0, 5'h00, 32'h0000_0020, "R5 sticky after source falls");
    chk("R8 irq for unmasked pending", {31'b0, irq_a}, 32'h1);
    pulse_a(2);
    rd(0, 5'h00, 32'h0000_0024, "R9 masked source still latched");
    wr(0, 5'h08, 32'h0000_0020);
    rd(0, 5'h00, 32'h0000_0004, "R6 only written bit cleared");
    chk("R8 R9 irq low with only masked pending", {31'b0, irq_a}, 32'h0);
    wr(0, 5'h14, 32'h0000_0004);
    chk("R9 irq returns on unmask", {31'b0, irq_a}, 32'h1);
    wr(0, 5'h08, 32'h0000_0004);
    rd(0, 5'h00, 32'h0, "R6 clear to empty");
    chk("R8 irq low when nothing pending", {31'b0, irq_a}, 32'h0);

    // R7: edge on bit 7 coincides with the clear of bits 6 and 7
    pulse_a(6);
    pulse_a(7);
    rd(0, 5'h00, 32'h0000_00C0, "R5 two pending bits");
    src_a[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(0, 5'h08, 32'h0000_00C0);
    src_a[7] = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, 5'h00, 32'h0000_0080, "R7 new edge beats clear");
    chk("R8 irq from surviving bit", {31'b0, irq_a}, 32'h1);
    wr(0, 5'h08, 32'h0000_0080);

    rd(0, 5'h04, 32'h0, "R12 unmapped read 0x04");
    rd(0, 5'h18, 32'h0, "R12 unmapped read 0x18");
    wr(0, 5'h04, 32'hFFFF_FFFF);
    wr(0, 5'h1C, 32'h0);
    wr(0, 5'h00, 32'hFFFF_FFFF);
    rd(0, 5'h0C, 32'hFFFF_FF0B, "R12 mask untouched by dead writes");
    rd(0, 5'h00, 32'h0, "R12 status untouched by dead writes");

    // Level variant
    rd(1, 5'h04, 32'hFFFF_FFFF, "R1 R11 level mask after reset");
    wr(1, 5'h0C, 32'h0000_00F0);
    rd(1, 5'h04, 32'hFFFF_FF0F, "R11 R3 level mask clear");
    wr(1, 5'h08, 32'h0000_0010);
    rd(1, 5'h04, 32'hFFFF_FF1F, "R11 R2 level mask set");
    src_b = 32'h0000_0060;
    repeat (4) @(negedge clk);
    rd(1, 5'h00, 32'h0000_0060, "R10 live level");
    chk("R8 level irq unmasked", {31'b0, irq_b}, 32'h1);
    src_b = 32'h0000_0010;
    repeat (4) @(negedge clk);
    rd(1, 5'h00, 32'h0000_0010, "R10 level follows input");
    chk("R8 level irq masked", {31'b0, irq_b}, 32'h0);
    src_b = 32'h0;
    repeat (4) @(negedge clk);
    rd(1, 5'h00, 32'h0, "R10 nothing held");
    wr(1, 5'h14, 32'hFFFF_FFFF);
    wr(1, 5'h10, 32'hFFFF_FFFF);
    rd(1, 5'h04, 32'hFFFF_FF1F, "R11 offsets 0x10 0x14 dead");
    rd(1, 5'h10, 32'h0, "R11 R12 unmapped read 0x10");

    repeat (3) @(negedge clk);
    chk("R12 all reads answered", q_a.size() + q_b.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule